// File: doc/BRIEF.md
# Critical-Word-First Cache-Line Burst Sequencer

This block orders the data beats of a single cache-line burst of 32 bytes (four 64-bit double words) on a data bus that can run 64 bits or 32 bits wide. When a burst is accepted, the block latches the transfer direction, the bus width and the double word that was asked for. From then on it presents, one beat at a time, which double word the current beat carries and, on the narrow bus, which half of it. It steps to the next beat on each data-acknowledge pulse.

Reads start at the double word the requester needs and wrap around the end of the line. Writes always walk the line from double word zero. On the narrow bus each double word takes two consecutive beats, upper word first. On a read the block also places each incoming beat into the correct slot of a line buffer. The buffer is built from two word-wide banks that map onto block RAM. A one-cycle pulse marks the moment the whole line has arrived. A consumer reads the assembled line back one 32-bit word at a time.

Top module: `cwf_burst_seq`

## Requirements
- R1: A write burst presents double words 0, 1, 2, 3 in that order, whatever the value of address bits 4:3.
- R2: A read burst presents first the double word given by address bits 4:3. The following beats rise by one and wrap from 3 to 0.
- R3: With `req_narrow` = 0 a burst has 4 beats, each covering a whole double word, and `beat_half` stays 0.
- R4: With `req_narrow` = 1 a burst has 8 beats. Each double word appears on two consecutive beats, first with `beat_half` = 0 (upper word, bits 63:32) and then with `beat_half` = 1 (lower word, bits 31:0).
- R5: Beat outputs change only after a cycle in which `ack` is high. Without `ack` they hold their values.
- R6: `beat_first` is high only on the first beat and `beat_last` only on the final beat. The cycle after `ack` on the final beat, `busy` is 0.
- R7: A request is accepted only when `busy` is 0. A request made during a burst changes neither the burst's order nor its width. The width is taken only from `req_narrow` at acceptance.
- R8: On read beats with `ack`, data is stored by word slot, where slot = 2·dw + half and half 0 is the upper word. In 64-bit mode `rd_data[63:32]` goes to the upper slot and `rd_data[31:0]` to the lower slot. In 32-bit mode `rd_data[31:0]` goes to the slot of the current half. `lb_rd_word` returns the slot addressed by `lb_rd_slot` one cycle later. Write bursts leave the buffer unchanged.
- R9: `line_valid` is high for exactly one cycle, the cycle after `ack` on the final beat of a read. It never rises for a write burst.
- R10: While `rst` is high and after it is released, `busy`, `beat_first`, `beat_last` and `line_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Burst request |
| req_addr | input | ADDR_W | Line address; bits 4:3 select the requested double word |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_narrow | input | 1 | 1 = 32-bit bus, 0 = 64-bit bus |
| ack | input | 1 | Data acknowledge; completes the current beat |
| rd_data | input | 64 | Read data; the narrow bus uses bits 31:0 |
| lb_rd_slot | input | IDX_W+1 | Line-buffer word slot to read |
| busy | output | 1 | Burst in progress |
| beat_dw | output | IDX_W | Double-word index of the current beat |
| beat_half | output | 1 | 0 = upper word, 1 = lower word (narrow bus only) |
| beat_first | output | 1 | Current beat is the first of the burst |
| beat_last | output | 1 | Current beat is the last of the burst |
| line_valid | output | 1 | One-cycle pulse: read line complete |
| lb_rd_word | output | 32 | Line-buffer word, one cycle after `lb_rd_slot` |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a four-double-word line. With these values all four starting offsets, in both bus widths and in both directions, come down to sixteen bursts, and the bench runs every one of them. It varies the number of idle cycles between acknowledges and drives conflicting requests during those idle cycles, which reaches the hold and ignore behaviour. Reading back the line buffer after each burst shows both the placement of each slot on reads and that write bursts leave the buffer untouched.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  localparam int WORD_W       = 32;
  localparam int DW_W         = 2 * WORD_W;
  localparam int DW_BYTE_BITS = 3;

  typedef enum logic {
    HALF_UPPER = 1'b0,
    HALF_LOWER = 1'b1
  } half_e;
endpackage

// File: rtl/cwf_beat_order.sv
module cwf_beat_order
  import cwf_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_DWS = 4,
  localparam int IDX_W   = $clog2(LINE_DWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic             req_write,
  input  logic             req_narrow,
  input  logic             ack,
  output logic             busy,
  output logic [IDX_W-1:0] beat_dw,
  output logic             beat_half,
  output logic             beat_first,
  output logic             beat_last,
  output logic             cur_write,
  output logic             cur_narrow,
  output logic             rd_done
);
  localparam int CNT_W       = IDX_W + 1;
  localparam int LAST_WIDE   = LINE_DWS - 1;
  localparam int LAST_NARROW = 2 * LINE_DWS - 1;

  logic             busy_q, write_q, narrow_q, first_q, last_q, half_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] start_q, dw_q;

  logic [IDX_W-1:0] offset, step_nx, dw_nx;
  logic [CNT_W-1:0] cnt_nx;
  logic             half_nx, last_nx, accept, fire;

  always_comb begin
    offset  = req_addr[DW_BYTE_BITS +: IDX_W];
    accept  = req_valid & ~busy_q;
    fire    = busy_q & ack;
    cnt_nx  = cnt_q + 1'b1;
    step_nx = narrow_q ? cnt_nx[CNT_W-1:1] : cnt_nx[IDX_W-1:0];
    dw_nx   = start_q + step_nx;
    half_nx = narrow_q & cnt_nx[0];
    last_nx = narrow_q ? (cnt_nx == CNT_W'(LAST_NARROW))
                       : (cnt_nx == CNT_W'(LAST_WIDE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      write_q  <= 1'b0;
      narrow_q <= 1'b0;
      first_q  <= 1'b0;
      last_q   <= 1'b0;
      half_q   <= HALF_UPPER;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      start_q  <= '0;
      dw_q     <= '0;
    end else begin
      done_q <= fire & last_q & ~write_q;
      if (accept) begin
        busy_q   <= 1'b1;
        write_q  <= req_write;
        narrow_q <= req_narrow;
        cnt_q    <= '0;
        start_q  <= req_write ? '0 : offset;
        dw_q     <= req_write ? '0 : offset;
        half_q   <= HALF_UPPER;
        first_q  <= 1'b1;
        last_q   <= 1'b0;
      end else if (fire) begin
        first_q <= 1'b0;
        if (last_q) begin
          busy_q <= 1'b0;
          last_q <= 1'b0;
        end else begin
          cnt_q  <= cnt_nx;
          dw_q   <= dw_nx;
          half_q <= half_nx;
          last_q <= last_nx;
        end
      end
    end
  end

  assign busy       = busy_q;
  assign beat_dw    = dw_q;
  assign beat_half  = half_q;
  assign beat_first = first_q;
  assign beat_last  = last_q;
  assign cur_write  = write_q;
  assign cur_narrow = narrow_q;
  assign rd_done    = done_q;

  // R1: a write burst opens on double word zero
  a_r1_write_starts_zero: assert property (@(posedge clk) disable iff (rst)
    busy_q && first_q && write_q |-> dw_q == '0);

  // R2: each completed double word is followed by the next one, modulo line size
  a_r2_ascending_wrap: assert property (@(posedge clk) disable iff (rst)
    busy_q && ack && !last_q && (!narrow_q || half_q)
      |=> busy_q && dw_q == IDX_W'($past(dw_q) + 1'b1));

  // R3: wide bus never selects a lower half
  a_r3_wide_no_half: assert property (@(posedge clk) disable iff (rst)
    busy_q && !narrow_q |-> !half_q);

  // R4: narrow bus sends upper then lower word of the same double word
  a_r4_upper_then_lower: assert property (@(posedge clk) disable iff (rst)
    busy_q && ack && narrow_q && !last_q && !half_q
      |=> half_q && $stable(dw_q));

  // R5: no acknowledge, no movement
  a_r5_hold_without_ack: assert property (@(posedge clk) disable iff (rst)
    busy_q && !ack |=> busy_q && $stable(dw_q) && $stable(half_q) && $stable(last_q));

  // R6: acknowledge on the final beat ends the burst
  a_r6_last_ends: assert property (@(posedge clk) disable iff (rst)
    busy_q && ack && last_q |=> !busy_q);

  // R7: requests during a burst leave its mode alone
  a_r7_ignore_busy_req: assert property (@(posedge clk) disable iff (rst)
    busy_q && req_valid && !(ack && last_q)
      |=> busy_q && $stable(narrow_q) && $stable(write_q));
endmodule

// File: rtl/cwf_lb_bank.sv
module cwf_lb_bank #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cwf_line_store.sv
module cwf_line_store
  import cwf_pkg::*;
#(
  parameter int LINE_DWS = 4,
  localparam int IDX_W   = $clog2(LINE_DWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_narrow,
  input  logic [IDX_W-1:0]  wr_dw,
  input  logic              wr_half,
  input  logic [DW_W-1:0]   wr_data,
  input  logic [IDX_W:0]    rd_slot,
  output logic [WORD_W-1:0] rd_word
);
  localparam int BANKS = 2;

  logic [WORD_W-1:0] bank_rd [BANKS];
  logic              sel_q;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic              b_we;
    logic [WORD_W-1:0] b_wdata;

    always_comb begin
      b_we = wr_en & (~wr_narrow | (wr_half == 1'(b)));
      if (wr_narrow)
        b_wdata = wr_data[WORD_W-1:0];
      else if (b == 0)
        b_wdata = wr_data[DW_W-1:WORD_W];
      else
        b_wdata = wr_data[WORD_W-1:0];
    end

    cwf_lb_bank #(.DEPTH(LINE_DWS), .WIDTH(WORD_W)) u_bank (
      .clk   (clk),
      .we    (b_we),
      .waddr (wr_dw),
      .wdata (b_wdata),
      .raddr (rd_slot[IDX_W:1]),
      .rdata (bank_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= HALF_UPPER;
    else     sel_q <= rd_slot[0];
  end

  assign rd_word = sel_q ? bank_rd[1] : bank_rd[0];
endmodule

// File: rtl/cwf_burst_seq.sv
module cwf_burst_seq
  import cwf_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_DWS = 4,
  localparam int IDX_W   = $clog2(LINE_DWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_narrow,
  input  logic              ack,
  input  logic [DW_W-1:0]   rd_data,
  input  logic [IDX_W:0]    lb_rd_slot,
  output logic              busy,
  output logic [IDX_W-1:0]  beat_dw,
  output logic              beat_half,
  output logic              beat_first,
  output logic              beat_last,
  output logic              line_valid,
  output logic [WORD_W-1:0] lb_rd_word
);
  logic cur_write, cur_narrow, rd_done, store_en;

  cwf_beat_order #(.ADDR_W(ADDR_W), .LINE_DWS(LINE_DWS)) u_order (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .req_narrow (req_narrow),
    .ack        (ack),
    .busy       (busy),
    .beat_dw    (beat_dw),
    .beat_half  (beat_half),
    .beat_first (beat_first),
    .beat_last  (beat_last),
    .cur_write  (cur_write),
    .cur_narrow (cur_narrow),
    .rd_done    (rd_done)
  );

  assign store_en   = busy & ack & ~cur_write;
  assign line_valid = rd_done;

  cwf_line_store #(.LINE_DWS(LINE_DWS)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (store_en),
    .wr_narrow (cur_narrow),
    .wr_dw     (beat_dw),
    .wr_half   (beat_half),
    .wr_data   (rd_data),
    .rd_slot   (lb_rd_slot),
    .rd_word   (lb_rd_word)
  );

  // R9: completion strobe lasts one cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    line_valid |=> !line_valid);

  // R9: a write burst never raises the completion strobe
  a_r9_no_pulse_on_write: assert property (@(posedge clk) disable iff (rst)
    busy && ack && beat_last && cur_write |=> !line_valid);

  // R6: first-beat flag only while a burst runs
  a_r6_first_inside_burst: assert property (@(posedge clk) disable iff (rst)
    beat_first || beat_last |-> busy);
endmodule

// File: tb/sim_cwf_burst_seq.sv
`timescale 1ns/1ps
module sim_cwf_burst_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_narrow = 1'b0;
  logic        ack = 1'b0;
  logic [63:0] rd_data = '0;
  logic [2:0]  lb_rd_slot = '0;
  logic        busy, beat_half, beat_first, beat_last, line_valid;
  logic [1:0]  beat_dw;
  logic [31:0] lb_rd_word;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;
  logic [31:0] model [8];

  always #10 clk = ~clk;

  cwf_burst_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_narrow(req_narrow), .ack(ack),
    .rd_data(rd_data), .lb_rd_slot(lb_rd_slot), .busy(busy),
    .beat_dw(beat_dw), .beat_half(beat_half), .beat_first(beat_first),
    .beat_last(beat_last), .line_valid(line_valid), .lb_rd_word(lb_rd_word)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // packed view of beat outputs: {busy, dw, half, first, last}
  function automatic logic [5:0] beat_vec();
    return {busy, beat_dw, beat_half, beat_first, beat_last};
  endfunction

  task automatic run_burst(input bit w, input bit n, input int o, input int gap);
    int nb  = n ? 8 : 4;
    int per = n ? 2 : 1;
    string tag = $sformatf("%s %s R6", w ? "R1" : "R2", n ? "R4" : "R3");
    req_valid  = 1'b1;
    req_addr   = ($urandom() & 32'hFFFF_FFE0) | (32'(o) << 3);
    req_write  = w;
    req_narrow = n;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < nb; k++) begin
      logic [1:0] edw = w ? 2'(k / per) : 2'((o + k / per) % 4);
      logic       eh  = n ? k[0] : 1'b0;
      logic [5:0] ev  = {1'b1, edw, eh, (k == 0), (k == nb - 1)};
      for (int i = 0; i < gap; i++) begin
        req_valid  = 1'b1;
        req_narrow = ~n;
        req_write  = ~w;
        req_addr   = $urandom();
        check(beat_vec() == ev, "R5 R7 hold", 64'(beat_vec()), 64'(ev));
        @(negedge clk);
      end
      req_valid = 1'b0;
      check(beat_vec() == ev, tag, 64'(beat_vec()), 64'(ev));
      ack     = 1'b1;
      rd_data = {$urandom(), $urandom()};
      if (!w) begin
        if (n) model[{edw, eh}] = rd_data[31:0];
        else begin
          model[{edw, 1'b0}] = rd_data[63:32];
          model[{edw, 1'b1}] = rd_data[31:0];
        end
      end
      @(negedge clk);
      ack = 1'b0;
    end
    check(busy == 1'b0, "R6 end", 64'(busy), 64'd0);
    check(line_valid == !w, "R9 pulse", 64'(line_valid), 64'(!w));
    @(negedge clk);
    check(line_valid == 1'b0, "R9 single", 64'(line_valid), 64'd0);
    for (int s = 0; s < 8; s++) begin
      lb_rd_slot = 3'(s);
      @(negedge clk);
      check(lb_rd_word == model[s], "R8 slot", 64'(lb_rd_word), 64'(model[s]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({busy, beat_first, beat_last, line_valid} == 4'b0, "R10 in reset",
          64'({busy, beat_first, beat_last, line_valid}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check({busy, beat_first, beat_last, line_valid} == 4'b0, "R10 after reset",
          64'({busy, beat_first, beat_last, line_valid}), 64'd0);
    for (int n = 0; n < 2; n++) begin
      for (int o = 0; o < 4; o++) begin
        run_burst(1'b0, n[0], o, (o + n) % 3);
        run_burst(1'b1, n[0], o, (o + 2 * n + 1) % 3);
      end
    end
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end
endmodule